// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when the temperature sensor is told to run a compensation conversion. A free-running interval counter advances on a one-second tick. When the interval that software selected runs out, it issues a periodic conversion. Software can also ask for a conversion at any time by writing the convert bit. That request runs apart from the interval counter and does not move it. Each conversion begins with a single-cycle start pulse to the sensor interface and ends when that interface returns a done pulse.

Two status bits can be read back. The convert flag stays set from an accepted software request until that conversion finishes. The busy flag shows a conversion in progress. After a software-requested start, busy is held low for a fixed number of clock cycles before it is allowed to report. All pins are plain control and status strobes. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `conv_scheduler`

## Requirements
- R1: After reset, `conv_start`, `conv_flag` and `busy_flag` are 0 and `rate_sel` is 00.
- R2: A write on `rate_wdata` selects the periodic interval as BASE_TICKS shifted left by the code: 00 gives 1x, 01 gives 2x, 10 gives 4x and 11 gives 8x (64, 128, 256 and 512 seconds with the default base). `rate_sel` returns the code. Counting from reset, a periodic start is issued on every interval-th `sec_tick`, in the cycle after that tick.
- R3: `conv_start` is high for exactly one cycle per conversion.
- R4: With no conversion in progress, a `conv_set` pulse makes `conv_start` and `conv_flag` go high in the next cycle.
- R5: While a conversion is in progress, a `conv_set` pulse produces no start pulse and leaves `conv_flag` unchanged, whether it was 0 or 1.
- R6: A `conv_done` pulse during a conversion clears `conv_flag` and `busy_flag` in the next cycle.
- R7: After a periodic start, `busy_flag` is 1 in the same cycle as the start pulse.
- R8: After a software start, `busy_flag` stays 0 until HOLD_CYCLES cycles after the start pulse, and is 1 from then until done.
- R9: Software conversions do not reset or shift the interval counter. Periodic starts stay on the same ticks.
- R10: A periodic start that falls due during a conversion is deferred. It is issued two cycles after the cycle that carries `conv_done`, which is one cycle after busy clears.
- R11: If a `conv_set` pulse and a due periodic start arrive in the same idle cycle, the software request starts first and the periodic one is deferred as in R10.
- R12: A rate change keeps the current count. If the count has already reached the new interval, the next tick issues a periodic start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| rate_we | input | 1 | Write strobe for the rate code |
| rate_wdata | input | 2 | Rate code to write |
| conv_set | input | 1 | Software wrote 1 to the convert bit |
| conv_done | input | 1 | Sensor interface finished the conversion |
| conv_start | output | 1 | Single-cycle conversion start |
| rate_sel | output | 2 | Current rate code |
| conv_flag | output | 1 | Software conversion pending or running |
| busy_flag | output | 1 | Conversion in progress, subject to the hold-off |

## Verification
The bench sweeps all four rate codes with a small base interval. A wrong shift or an off-by-one compare would put the periodic starts on the wrong ticks. It watches busy cycle by cycle after a software start, so a hold-off that is too short or too long shows up on a named cycle. It places a periodic deadline inside a software conversion, and also on the same cycle as a software request. A design that drops or doubles the deferred start, or restarts the interval counter, then misses the next scheduled tick. It also issues convert writes during both kinds of conversion, and shrinks the rate code below the running count.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef logic [1:0] rate_code_t;
endpackage

// File: rtl/conv_interval_timer.sv
module conv_interval_timer #(
  parameter int BASE_TICKS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sec_tick,
  input  conv_sched_pkg::rate_code_t  rate,
  output logic                        due
);
  localparam int MAX_IVL = BASE_TICKS * 8;
  localparam int CW      = $clog2(MAX_IVL + 1);

  logic [CW-1:0] cnt, nxt, limit;

  assign limit = CW'(BASE_TICKS) << rate;
  assign nxt   = cnt + 1'b1;
  // >= so that a shrunk interval fires on the next tick
  assign due   = sec_tick && (nxt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (sec_tick) cnt <= due ? '0 : nxt;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(MAX_IVL));
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> cnt == '0);
endmodule

// File: rtl/conv_status_hold.sv
module conv_status_hold #(
  parameter int HOLD_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic expired
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= HW'(HOLD_CYCLES);
    else if (clear)      cnt <= '0;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);
endmodule

// File: rtl/conv_scheduler.sv
module conv_scheduler #(
  parameter int BASE_TICKS  = 64,
  parameter int HOLD_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       rate_we,
  input  logic [1:0] rate_wdata,
  input  logic       conv_set,
  input  logic       conv_done,
  output logic       conv_start,
  output logic [1:0] rate_sel,
  output logic       conv_flag,
  output logic       busy_flag
);
  import conv_sched_pkg::*;

  rate_code_t rate_q;
  logic active, pending, due, hold_done;
  logic user_go, per_go, finish;

  always_ff @(posedge clk) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_we) rate_q <= rate_wdata;
  end

  conv_interval_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rate(rate_q), .due(due)
  );

  // software request wins an idle cycle; periodic work waits in pending
  assign user_go = !active && conv_set;
  assign per_go  = !active && !user_go && (due || pending);
  assign finish  = active && conv_done;

  conv_status_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(user_go), .clear(per_go || finish),
    .expired(hold_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      active     <= 1'b0;
      pending    <= 1'b0;
      conv_flag  <= 1'b0;
    end else begin
      conv_start <= user_go || per_go;
      if (user_go || per_go) active <= 1'b1;
      else if (finish)       active <= 1'b0;
      if (user_go)     conv_flag <= 1'b1;
      else if (finish) conv_flag <= 1'b0;
      if (per_go)                      pending <= 1'b0;
      else if (due && (active || user_go)) pending <= 1'b1;
    end
  end

  assign busy_flag = active && hold_done;
  assign rate_sel  = rate_q;

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && conv_set) |=> (conv_start && conv_flag));
  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && conv_set) |=> !conv_start);
  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!conv_flag && !busy_flag));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_flag) |-> !busy_flag);
  p_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !active) |=> conv_start);
endmodule

// File: tb/conv_scheduler_test.sv
module conv_scheduler_test;
  localparam int BASE = 4;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, rate_we = 1'b0, conv_set = 1'b0, conv_done = 1'b0;
  logic [1:0] rate_wdata = 2'b00;
  logic conv_start, conv_flag, busy_flag;
  logic [1:0] rate_sel;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  conv_scheduler #(.BASE_TICKS(BASE), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rate_we(rate_we),
    .rate_wdata(rate_wdata), .conv_set(conv_set), .conv_done(conv_done),
    .conv_start(conv_start), .rate_sel(rate_sel), .conv_flag(conv_flag),
    .busy_flag(busy_flag)
  );

  task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic idle(); @(negedge clk); endtask
  task automatic do_tick(); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; endtask
  task automatic do_set(); conv_set = 1'b1; @(negedge clk); conv_set = 1'b0; endtask
  task automatic do_done(); conv_done = 1'b1; @(negedge clk); conv_done = 1'b0; endtask
  task automatic do_rate(input logic [1:0] r);
    rate_we = 1'b1; rate_wdata = r; @(negedge clk); rate_we = 1'b0;
  endtask
  task automatic do_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk(conv_start, 0, "R1 start"); chk(conv_flag, 0, "R1 conv");
    chk(busy_flag, 0, "R1 busy");   chk(rate_sel, 0, "R1 rate");

    // R2, R3, R6, R7: sweep of rate codes
    for (int r = 0; r < 4; r++) begin
      do_reset();
      do_rate(2'(r));
      chk(rate_sel, 2'(r), "R2 rate readback");
      for (int k = 1; k <= 2 * (BASE << r); k++) begin
        do_tick();
        chk(conv_start, 2'((k % (BASE << r)) == 0), "R2 periodic start");
        if ((k % (BASE << r)) == 0) begin
          chk(busy_flag, 1, "R7 busy at periodic start");
          idle();
          chk(conv_start, 0, "R3 pulse width");
          do_done();
          chk(busy_flag, 0, "R6 busy clear");
        end
      end
    end

    // R4, R5, R8, R6: software conversion
    do_reset();
    do_set();
    chk(conv_start, 1, "R4 start"); chk(conv_flag, 1, "R4 conv");
    chk(busy_flag, 0, "R8 busy held");
    for (int j = 1; j <= HOLD + 1; j++) begin
      idle();
      chk(busy_flag, 2'(j >= HOLD), "R8 busy after hold");
    end
    do_set();
    chk(conv_start, 0, "R5 no restart"); chk(conv_flag, 1, "R5 conv kept 1");
    do_done();
    chk(conv_flag, 0, "R6 conv clear"); chk(busy_flag, 0, "R6 busy clear");

    // R9, R10, R5: deferral inside software conversion
    do_reset();
    do_tick(); do_tick();
    do_set();
    do_tick();
    do_tick();
    chk(conv_start, 0, "R10 deferred while active");
    do_done();
    chk(conv_start, 0, "R10 not yet"); chk(busy_flag, 0, "R10 busy clear");
    idle();
    chk(conv_start, 1, "R10 deferred start"); chk(busy_flag, 1, "R10 busy");
    do_set();
    chk(conv_start, 0, "R5 ignored in periodic"); chk(conv_flag, 0, "R5 conv kept 0");
    do_done();
    for (int k = 5; k <= 8; k++) begin
      do_tick();
      chk(conv_start, 2'(k == 8), "R9 interval undisturbed");
    end
    do_done();

    // R11: collision in an idle cycle
    do_tick(); do_tick(); do_tick();
    sec_tick = 1'b1; conv_set = 1'b1; @(negedge clk); sec_tick = 1'b0; conv_set = 1'b0;
    chk(conv_start, 1, "R11 user first"); chk(conv_flag, 1, "R11 conv");
    chk(busy_flag, 0, "R11 busy held");
    do_done();
    idle();
    chk(conv_start, 1, "R11 periodic after"); chk(conv_flag, 0, "R11 conv 0");
    chk(busy_flag, 1, "R11 busy");
    do_done();

    // R12: rate shrink below running count
    do_reset();
    do_rate(2'd3);
    for (int k = 0; k < 10; k++) begin
      do_tick();
      chk(conv_start, 0, "R12 no start at long rate");
    end
    do_rate(2'd0);
    do_tick();
    chk(conv_start, 1, "R12 fires after shrink");
    do_done();
    for (int k = 1; k <= 4; k++) begin
      do_tick();
      chk(conv_start, 2'(k == 4), "R12 new interval");
    end
    do_done();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule